// File: doc/BRIEF.md
# Synchronous Burst Memory Core

This block is a single-port synchronous memory with a 64-bit word and a built-in four-beat burst sequencer. Every control, address and data input is captured on the rising clock edge. An access sequence opens when the address strobe and the chip enable are both low. At that edge the full address is loaded. After that, a two-bit counter supplies the two low address bits. The counter steps once per clock while the advance input is low, and it holds its value on wait cycles.

Two write paths are supported. A global write always stores the whole word. A byte-write enable qualifies eight per-lane strobes. Any selected cycle that decodes no write is a read. The read word is registered and presented on the output in the following cycle, together with an output-enable flag. The flag is low, and the data output is zero, after writes and while the chip is deselected. A surrounding pad ring turns the pair into a shared tri-state bus.

The depth is 2**AW words. The full-size part uses AW = 16; the default is smaller so that simulation stays light.

Top module: `sbsram_core`

## Requirements
- R1: When strobe_n and cen_n are both low at a rising edge, the access of that edge uses adr_i, and the counter loads adr_i[1:0].
- R2: On a cycle with an open sequence, strobe_n high and adv_n low, the counter steps linearly modulo 4. The access uses the upper address bits loaded at the start and the new counter value, so address 3 is followed by address 0 of the same 4-word block.
- R3: On a cycle with an open sequence, strobe_n high and adv_n high, the counter holds and the access repeats the same address.
- R4: With gwr_n low on a selected cycle, all 64 bits are written, whatever the values of bwe_n and lane_n.
- R5: With gwr_n high and bwe_n low, byte lane k (data bits 8k+7 to 8k) is written exactly when lane_n[k] is low; the other lanes keep their contents.
- R6: With gwr_n and bwe_n both high, the selected cycle is a read and lane_n has no effect on memory.
- R7: A read at rising edge n shows dq_oe = 1 and the addressed word on dq_o from edge n until edge n+1.
- R8: After a write edge, dq_oe is 0 and dq_o is all zeros for the next cycle.
- R9: strobe_n low with cen_n high closes the sequence: no access occurs, dq_oe goes to 0, and later cycles with strobe_n high (advance or write controls included) make no access until a new start.
- R10: While rst_n is low, and after it is released, the block has no open sequence and dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| adr_i | input | AW | Word address, loaded at a start |
| strobe_n | input | 1 | Active-low address strobe, starts or closes a sequence |
| cen_n | input | 1 | Active-low chip enable, qualifies the strobe |
| adv_n | input | 1 | Active-low burst advance |
| gwr_n | input | 1 | Active-low global (full-word) write |
| bwe_n | input | 1 | Active-low byte-write enable |
| lane_n | input | 8 | Active-low per-lane write strobes, bit k covers data bits 8k+7..8k |
| dq_i | input | 64 | Write data |
| dq_o | output | 64 | Read data, zero when not driving |
| dq_oe | output | 1 | High while dq_o carries read data |

## Verification
The sequencer is driven through a full burst that starts mid-block at offset 2 and wraps to offset 0. This shows linear modulo-4 stepping rather than another order. A wait cycle is placed inside a read burst, which separates holding the address from stepping it. Writes are tried in three forms: global write with the byte controls active and the strobes off, a sparse lane pattern under the byte enable, and byte strobes with the enable high. Read-back then shows that the global write overrides the byte controls, that only the strobed lanes change, and that the strobes alone do nothing. Advance and write pulses sent after a deselect show that a closed sequence makes no access.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int CNT_W  = 2;

  // Linear modulo-4 burst step.
  function automatic logic [CNT_W-1:0] burst_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // Per-lane write mask: global write wins, then byte enable gates strobes.
  function automatic logic [LANES-1:0] lane_mask(input logic g_n,
                                                 input logic b_n,
                                                 input logic [LANES-1:0] l_n);
    if (!g_n)      return '1;
    else if (!b_n) return ~l_n;
    else           return '0;
  endfunction
endpackage

// File: rtl/sbsram_seq.sv
`timescale 1ns/1ps
module sbsram_seq #(
  parameter int AW = 8,
  parameter int CW = sbsram_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] adr_i,
  input  logic          strobe_n,
  input  logic          cen_n,
  input  logic          adv_n,
  output logic [AW-1:0] eff_addr,
  output logic          sel,
  output logic          start_ev,
  output logic          desel_ev,
  output logic          adv_ev,
  output logic          active,
  output logic [CW-1:0] cnt
);
  localparam int HW = AW - CW;

  logic [HW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [CW-1:0] cnt_nx;

  assign start_ev = !strobe_n && !cen_n;
  assign desel_ev = !strobe_n && cen_n;
  assign adv_ev   = act_q && strobe_n && !adv_n;
  assign sel      = start_ev || (act_q && strobe_n);
  assign cnt_nx   = adv_ev ? sbsram_pkg::burst_step(cnt_q) : cnt_q;
  assign eff_addr = start_ev ? adr_i : {base_q, cnt_nx};
  assign active   = act_q;
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start_ev) begin
      act_q  <= 1'b1;
      cnt_q  <= adr_i[CW-1:0];
      base_q <= adr_i[AW-1:CW];
    end else if (desel_ev) begin
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/sbsram_wdec.sv
`timescale 1ns/1ps
module sbsram_wdec #(
  parameter int NL = sbsram_pkg::LANES
) (
  input  logic          gwr_n,
  input  logic          bwe_n,
  input  logic [NL-1:0] lane_n,
  output logic [NL-1:0] wmask,
  output logic          wr_any
);
  assign wmask  = sbsram_pkg::lane_mask(gwr_n, bwe_n, lane_n);
  assign wr_any = |wmask;
endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
module sbsram_array #(
  parameter int AW = 8,
  parameter int NL = sbsram_pkg::LANES,
  parameter int LW = sbsram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             sel,
  input  logic [AW-1:0]    addr,
  input  logic [NL-1:0]    wmask,
  input  logic             wr_any,
  input  logic [NL*LW-1:0] wdata,
  output logic [NL*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (sel && wmask[g]) mem[addr] <= wdata[g*LW +: LW];
      if (sel && !wr_any)  rd_q      <= mem[addr];
    end
    assign rdata[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/sbsram_oe.sv
`timescale 1ns/1ps
module sbsram_oe (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic wr_any,
  output logic oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe <= 1'b0;
    else        oe <= sel && !wr_any;
  end
endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core #(
  parameter int AW = 8,
  parameter int NL = sbsram_pkg::LANES,
  parameter int LW = sbsram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    adr_i,
  input  logic             strobe_n,
  input  logic             cen_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [NL-1:0]    lane_n,
  input  logic [NL*LW-1:0] dq_i,
  output logic [NL*LW-1:0] dq_o,
  output logic             dq_oe
);
  localparam int CW = sbsram_pkg::CNT_W;

  logic [AW-1:0]    eff_addr;
  logic             sel, start_ev, desel_ev, adv_ev, active;
  logic [CW-1:0]    cnt;
  logic [NL-1:0]    wmask;
  logic             wr_any;
  logic [NL*LW-1:0] rdata;

  sbsram_seq #(.AW(AW), .CW(CW)) seq_i (
    .clk(clk), .rst_n(rst_n), .adr_i(adr_i), .strobe_n(strobe_n),
    .cen_n(cen_n), .adv_n(adv_n), .eff_addr(eff_addr), .sel(sel),
    .start_ev(start_ev), .desel_ev(desel_ev), .adv_ev(adv_ev),
    .active(active), .cnt(cnt)
  );

  sbsram_wdec #(.NL(NL)) wdec_i (
    .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_n(lane_n),
    .wmask(wmask), .wr_any(wr_any)
  );

  sbsram_array #(.AW(AW), .NL(NL), .LW(LW)) array_i (
    .clk(clk), .sel(sel), .addr(eff_addr), .wmask(wmask),
    .wr_any(wr_any), .wdata(dq_i), .rdata(rdata)
  );

  sbsram_oe oe_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_any(wr_any), .oe(dq_oe)
  );

  assign dq_o = dq_oe ? rdata : '0;
endmodule

// File: rtl/sbsram_core_chk.sv
`timescale 1ns/1ps
module sbsram_core_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_ev,
  input logic          desel_ev,
  input logic          adv_ev,
  input logic          active,
  input logic          sel,
  input logic          strobe_n,
  input logic          adv_n,
  input logic          gwr_n,
  input logic          wr_any,
  input logic [7:0]    wmask,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] adr_lo,
  input logic          dq_oe
);
  assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (cnt == $past(adr_lo)));

  assert_burst_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (cnt == $past(cnt) + 1'b1));

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe_n && adv_n) |=> $stable(cnt));

  assert_global_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !gwr_n) |-> (&wmask));

  assert_read_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_any) |=> dq_oe);

  assert_write_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_any) |=> !dq_oe);

  assert_desel_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desel_ev |=> (!dq_oe && !active));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !dq_oe);
endmodule

bind sbsram_core sbsram_core_chk #(.CW(sbsram_pkg::CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .desel_ev(desel_ev),
  .adv_ev(adv_ev), .active(active), .sel(sel), .strobe_n(strobe_n),
  .adv_n(adv_n), .gwr_n(gwr_n), .wr_any(wr_any), .wmask(wmask),
  .cnt(cnt), .adr_lo(adr_i[1:0]), .dq_oe(dq_oe)
);

// File: tb/sbsram_core_tb_top.sv
`timescale 1ns/1ps
module sbsram_core_tb_top;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] adr_i = '0;
  logic        strobe_n = 1'b1, cen_n = 1'b1, adv_n = 1'b1;
  logic        gwr_n = 1'b1, bwe_n = 1'b1;
  logic [7:0]  lane_n = 8'hFF;
  logic [63:0] dq_i = '0;
  logic [63:0] dq_o;
  logic        dq_oe;

  always #10 clk = ~clk;

  sbsram_core #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .adr_i(adr_i), .strobe_n(strobe_n),
    .cen_n(cen_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwe_n(bwe_n),
    .lane_n(lane_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // scoreboard queues
  bit          q_oe[$];
  logic [63:0] q_d[$];
  string       q_tag[$];

  // bench reference state
  logic [63:0]   refm [256];
  bit            r_open = 0;
  logic [AW-3:0] r_hi = '0;
  logic [1:0]    r_lo = '0;

  task automatic cyc(input logic s_n, input logic c_n, input logic a_n,
                     input logic g_n, input logic b_n, input logic [7:0] l_n,
                     input logic [AW-1:0] a, input logic [63:0] d,
                     input string tag);
    bit         acc;
    logic [AW-1:0] ea;
    logic [7:0] m;
    @(negedge clk);
    strobe_n = s_n; cen_n = c_n; adv_n = a_n; gwr_n = g_n; bwe_n = b_n;
    lane_n = l_n; adr_i = a; dq_i = d;
    acc = 0; ea = '0;
    if (!s_n && !c_n) begin
      acc = 1; ea = a; r_open = 1; r_hi = a[AW-1:2]; r_lo = a[1:0];
    end else if (!s_n) begin
      r_open = 0;
    end else if (r_open) begin
      acc = 1;
      if (!a_n) r_lo = r_lo + 2'd1;
      ea = {r_hi, r_lo};
    end
    if (!g_n) m = 8'hFF;
    else if (!b_n) m = ~l_n;
    else m = 8'h00;
    if (acc && m != 0) begin
      for (int k = 0; k < 8; k++)
        if (m[k]) refm[ea][k*8 +: 8] = d[k*8 +: 8];
      q_oe.push_back(0); q_d.push_back(64'h0);
    end else if (acc) begin
      q_oe.push_back(1); q_d.push_back(refm[ea]);
    end else begin
      q_oe.push_back(0); q_d.push_back(64'h0);
    end
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1, 1, 1, 1, 1, 8'hFF, '0, '0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && q_oe.size() > 0) begin
        bit eo; logic [63:0] ed; string t;
        eo = q_oe.pop_front(); ed = q_d.pop_front(); t = q_tag.pop_front();
        total++;
        if (dq_oe !== eo) begin
          bad++;
          $display("FAIL %s: dq_oe=%b expected %b", t, dq_oe, eo);
        end else if (dq_o !== ed) begin
          bad++;
          $display("FAIL %s: dq_o=%h expected %h", t, dq_o, ed);
        end
      end
    end
  end

  // reset-time check
  initial begin
    #35;
    total++;
    if (dq_oe !== 1'b0) begin
      bad++;
      $display("FAIL R10 in reset: dq_oe=%b expected 0", dq_oe);
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R10 idle after reset");
    idle("R10 idle after reset");
    // global burst write starting at offset 2, wraps to 0
    cyc(0, 0, 1, 0, 1, 8'hFF, 8'h12, 64'h1111_2222_3333_4444, "R1 R4 start write");
    cyc(1, 0, 0, 0, 1, 8'hFF, '0, 64'h5555_6666_7777_8888, "R2 R8 adv write");
    cyc(1, 0, 0, 0, 1, 8'hFF, '0, 64'h9999_AAAA_BBBB_CCCC, "R2 wrap write");
    cyc(1, 0, 0, 0, 1, 8'hFF, '0, 64'hDDDD_EEEE_FFFF_0101, "R2 adv write");
    // read burst with a wait cycle
    cyc(0, 0, 1, 1, 1, 8'hFF, 8'h12, '0, "R1 R7 start read");
    cyc(1, 0, 0, 1, 1, 8'hFF, '0, '0, "R2 R7 adv read");
    cyc(1, 0, 0, 1, 1, 8'hFF, '0, '0, "R2 wrap read");
    cyc(1, 0, 1, 1, 1, 8'hFF, '0, '0, "R3 wait read");
    cyc(1, 0, 0, 1, 1, 8'hFF, '0, '0, "R2 R3 adv after wait");
    // global write overrides byte controls
    cyc(0, 0, 1, 0, 0, 8'hFF, 8'h20, 64'h0123_4567_89AB_CDEF, "R4 global over byte");
    cyc(1, 0, 1, 1, 1, 8'hFF, '0, '0, "R4 readback");
    // sparse byte write
    cyc(0, 0, 1, 1, 0, 8'b1010_0101, 8'h20, 64'hA0A1_A2A3_A4A5_A6A7, "R5 byte write");
    cyc(1, 0, 1, 1, 1, 8'hFF, '0, '0, "R5 readback");
    // strobes without enable: read, no change
    cyc(0, 0, 1, 1, 1, 8'h00, 8'h20, 64'hFFFF_FFFF_FFFF_FFFF, "R6 strobes only");
    cyc(1, 0, 1, 1, 1, 8'h00, '0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 readback");
    // deselect, then attempts with strobe high
    cyc(0, 1, 1, 1, 1, 8'hFF, 8'h20, '0, "R9 deselect");
    cyc(1, 0, 0, 1, 1, 8'hFF, '0, '0, "R9 adv ignored");
    cyc(1, 0, 1, 0, 1, 8'hFF, 8'h20, 64'hDEAD_BEEF_DEAD_BEEF, "R9 write ignored");
    cyc(1, 1, 1, 1, 1, 8'hFF, '0, '0, "R9 idle");
    cyc(0, 0, 1, 1, 1, 8'hFF, 8'h20, '0, "R9 R7 reread 0x20");
    cyc(1, 0, 1, 1, 1, 8'hFF, '0, '0, "R3 repeat 0x20");
    cyc(0, 0, 1, 1, 1, 8'hFF, 8'h13, '0, "R1 reread 0x13");
    idle("R9 tail idle");
    idle("R9 tail idle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // watchdog
  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule